// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar in packed BCD fields. It holds a tenths-of-second counter, seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week index. A 10 Hz enable pulse drives it. The tenths counter is also the one-second divider: each tenth pulse past 9 carries into the seconds. That carry can ripple through every field within a single clock cycle, so all fields change together.

Software loads a complete time through the write port, and only while the write-enable control input is high. An accepted load clears the tenths counter. A completion strobe, also gated by write-enable, starts the counting if it had not started and resets the tenths phase to zero. Until the first such strobe after reset, the clock holds its value. The hour field carries a format bit. With that bit set, hours run from 00 to 23. With it clear, hours run 12, 1, 2, … 11, and a separate flag marks the afternoon. The leap-year rule looks only at the two-digit year.

Top module: `bcd_calendar_top`

## Requirements
- R1: After reset the outputs read tenths 0, time 12:00:00 in 12-hour format with the afternoon flag clear (hour = 8'h12), day 8'h01, month 8'h01, year 8'h00, weekday 0, and `running` = 0. Tick pulses change nothing until a valid completion strobe arrives.
- R2: While `running` = 1, each `tick_en` cycle steps `tenths` by one. The step from 9 returns it to 0 and advances the seconds by one in the same cycle.
- R3: Seconds and minutes are packed BCD (high digit in bits 7:4) and count 8'h00 to 8'h59. The wrap from 59 to 00 carries into the next field in the same cycle.
- R4: When hour bit 7 = 1, the clock uses 24-hour format: bits 5:0 hold BCD 00 to 23. The step from 23 gives 8'h80 and advances the day.
- R5: When hour bit 7 = 0, the clock uses 12-hour format. Bits 4:0 hold BCD 01 to 12, and bit 5 = 1 means afternoon. The sequence is 12, 1, … 11. The step from 11 to 12 flips bit 5. The step from 11 afternoon to 12 morning advances the day.
- R6: Months 8'h04, 8'h06, 8'h09 and 8'h11 have 30 days, month 8'h02 has 28 or 29, and all other months have 31. Past the last day, the day returns to 8'h01 and the month advances. Past month 8'h12, the month returns to 8'h01 and the year advances, with 8'h99 wrapping to 8'h00.
- R7: February has a 29th day when the two-digit year is divisible by 4, including 00. No century exception applies.
- R8: The weekday is a 3-bit index that advances with each day change, stepping 0 to 6 and then back to 0.
- R9: A `wr_stb` pulse with `wr_en` = 1 loads all seven fields in one cycle and wins over a coincident tick. A `wr_stb` pulse with `wr_en` = 0 changes nothing.
- R10: An accepted load clears `tenths` to 0.
- R11: A `wr_done` pulse with `wr_en` = 1 sets `running` to 1, where it stays until reset, and returns `tenths` to 0. A `wr_done` pulse with `wr_en` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 10 Hz enable pulse, one clock wide |
| wr_en | input | 1 | Write-enable control bit for loads and completion strobes |
| wr_stb | input | 1 | Load all fields from the wr_* inputs |
| wr_done | input | 1 | Write completion strobe |
| wr_sec | input | 8 | Seconds to load (BCD) |
| wr_min | input | 8 | Minutes to load (BCD) |
| wr_hour | input | 8 | Hour to load: bit 7 format, bit 5 afternoon, BCD hour |
| wr_date | input | 8 | Day of month to load (BCD) |
| wr_month | input | 8 | Month to load (BCD) |
| wr_year | input | 8 | Year to load (BCD) |
| wr_dow | input | 3 | Weekday to load |
| tenths | output | 4 | Tenths-of-second counter |
| sec | output | 8 | Seconds (BCD) |
| min | output | 8 | Minutes (BCD) |
| hour | output | 8 | Hour field |
| date | output | 8 | Day of month (BCD) |
| month | output | 8 | Month (BCD) |
| year | output | 8 | Year (BCD) |
| dow | output | 3 | Weekday index |
| running | output | 1 | Counting has been started |

## Verification
The bench goes after the digit-boundary carries and the day-end case where one tick changes every field. A design that got the BCD carry wrong would show 8'h0A after 8'h09, and a broken ripple would leave minutes or the date one step behind. It also checks February in years 00, 10, 23 and 24, the 30-day months, and both 12-hour rollovers. A design with a swapped afternoon flag would advance the date at noon instead of at midnight. Finally, it checks a load coinciding with a tick, and a completion strobe in the middle of a second, which must delay the next seconds step by a full ten ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned DIG_W    = 4;
  localparam int unsigned FLD_W    = 2 * DIG_W;
  localparam int unsigned DOW_W    = 3;
  localparam int unsigned SUB_LAST = 9;
  localparam int unsigned DOW_LAST = 6;

  typedef logic [FLD_W-1:0] bcd_t;

  // Add one to a two-digit BCD value; the caller bounds the range.
  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[DIG_W-1:0] == DIG_W'(9))
      r = {v[FLD_W-1:DIG_W] + DIG_W'(1), DIG_W'(0)};
    else
      r = {v[FLD_W-1:DIG_W], v[DIG_W-1:0] + DIG_W'(1)};
    return r;
  endfunction

  // 10*t+u is divisible by 4 exactly when 2*t+u is.
  function automatic logic is_leap(input bcd_t yr);
    logic [DIG_W:0] s;
    s = {yr[FLD_W-1:DIG_W], 1'b0} + {1'b0, yr[DIG_W-1:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
    bcd_t r;
    case (mon)
      8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe[STAGES-1];
endmodule

// File: rtl/cal_subsec.sv
module cal_subsec #(
  parameter int unsigned W    = 4,
  parameter int unsigned LAST = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic [W-1:0] cnt_d;
  logic         step;
  logic         en;

  assign step  = run & tick & ~clr;
  assign carry = step & (cnt == LAST_V);
  assign en    = step | clr;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = (cnt == LAST_V) ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_d;
  end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_carry,
  input  logic load,
  input  bcd_t ld_sec,
  input  bcd_t ld_min,
  input  bcd_t ld_hour,
  output bcd_t sec,
  output bcd_t min,
  output bcd_t hour,
  output logic day_carry
);
  localparam bcd_t MS_LAST   = 8'h59;
  localparam bcd_t H24_LAST  = 8'h23;
  localparam bcd_t H12_TOP   = 8'h12;
  localparam bcd_t H12_TURN  = 8'h11;
  localparam bcd_t HOUR_RST  = 8'h12;

  bcd_t sec_d, min_d, hour_d;
  bcd_t h24, h12;
  logic pm;
  logic en;

  assign h24 = {2'b00, hour[5:0]};
  assign h12 = {3'b000, hour[4:0]};
  assign pm  = hour[5];
  assign en  = load | sec_carry;

  always_comb begin
    sec_d     = sec;
    min_d     = min;
    hour_d    = hour;
    day_carry = 1'b0;
    if (load) begin
      sec_d  = ld_sec;
      min_d  = ld_min;
      hour_d = ld_hour;
    end else if (sec_carry) begin
      if (sec != MS_LAST) begin
        sec_d = bcd_inc(sec);
      end else begin
        sec_d = '0;
        if (min != MS_LAST) begin
          min_d = bcd_inc(min);
        end else begin
          min_d = '0;
          if (hour[7]) begin
            if (h24 == H24_LAST) begin
              hour_d    = 8'h80;
              day_carry = 1'b1;
            end else begin
              hour_d = {2'b10, 6'(bcd_inc(h24))};
            end
          end else begin
            if (h12 == H12_TOP) begin
              hour_d = {2'b00, pm, 5'h01};
            end else if (h12 == H12_TURN) begin
              hour_d    = {2'b00, ~pm, 5'h12};
              day_carry = pm;
            end else begin
              hour_d = {2'b00, pm, 5'(bcd_inc(h12))};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= HOUR_RST;
    end else if (en) begin
      sec  <= sec_d;
      min  <= min_d;
      hour <= hour_d;
    end
  end
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             day_in,
  input  logic             load,
  input  bcd_t             ld_date,
  input  bcd_t             ld_month,
  input  bcd_t             ld_year,
  input  logic [DOW_W-1:0] ld_dow,
  output bcd_t             date,
  output bcd_t             month,
  output bcd_t             year,
  output logic [DOW_W-1:0] dow
);
  localparam logic [DOW_W-1:0] DOW_END = DOW_W'(DOW_LAST);
  localparam bcd_t MON_LAST  = 8'h12;
  localparam bcd_t YEAR_LAST = 8'h99;

  bcd_t             date_d, month_d, year_d;
  logic [DOW_W-1:0] dow_d;
  bcd_t             last_day;
  logic             en;

  assign last_day = month_len(month, year);
  assign en       = load | day_in;

  always_comb begin
    date_d  = date;
    month_d = month;
    year_d  = year;
    dow_d   = dow;
    if (load) begin
      date_d  = ld_date;
      month_d = ld_month;
      year_d  = ld_year;
      dow_d   = ld_dow;
    end else if (day_in) begin
      dow_d = (dow >= DOW_END) ? '0 : dow + DOW_W'(1);
      if (date >= last_day) begin
        date_d = 8'h01;
        if (month >= MON_LAST) begin
          month_d = 8'h01;
          year_d  = (year == YEAR_LAST) ? '0 : bcd_inc(year);
        end else begin
          month_d = bcd_inc(month);
        end
      end else begin
        date_d = bcd_inc(date);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date  <= 8'h01;
      month <= 8'h01;
      year  <= '0;
      dow   <= '0;
    end else if (en) begin
      date  <= date_d;
      month <= month_d;
      year  <= year_d;
      dow   <= dow_d;
    end
  end
endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_stb,
  input  logic             wr_done,
  input  logic [FLD_W-1:0] wr_sec,
  input  logic [FLD_W-1:0] wr_min,
  input  logic [FLD_W-1:0] wr_hour,
  input  logic [FLD_W-1:0] wr_date,
  input  logic [FLD_W-1:0] wr_month,
  input  logic [FLD_W-1:0] wr_year,
  input  logic [DOW_W-1:0] wr_dow,
  output logic [DIG_W-1:0] tenths,
  output logic [FLD_W-1:0] sec,
  output logic [FLD_W-1:0] min,
  output logic [FLD_W-1:0] hour,
  output logic [FLD_W-1:0] date,
  output logic [FLD_W-1:0] month,
  output logic [FLD_W-1:0] year,
  output logic [DOW_W-1:0] dow,
  output logic             running
);
  logic rst_sync_n;
  logic load_acc;
  logic done_acc;
  logic sec_carry;
  logic day_carry;

  assign load_acc = wr_en & wr_stb;
  assign done_acc = wr_en & wr_done;

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   running <= 1'b0;
    else if (done_acc) running <= 1'b1;
  end

  cal_subsec #(.W(DIG_W), .LAST(SUB_LAST)) u_sub (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (running),
    .tick  (tick_en),
    .clr   (load_acc | done_acc),
    .cnt   (tenths),
    .carry (sec_carry)
  );

  cal_clock u_clk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sec_carry (sec_carry),
    .load      (load_acc),
    .ld_sec    (wr_sec),
    .ld_min    (wr_min),
    .ld_hour   (wr_hour),
    .sec       (sec),
    .min       (min),
    .hour      (hour),
    .day_carry (day_carry)
  );

  cal_date u_date (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .day_in   (day_carry),
    .load     (load_acc),
    .ld_date  (wr_date),
    .ld_month (wr_month),
    .ld_year  (wr_year),
    .ld_dow   (wr_dow),
    .date     (date),
    .month    (month),
    .year     (year),
    .dow      (dow)
  );
endmodule

// File: rtl/cal_chk.sv
module cal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       wr_en,
  input logic       wr_stb,
  input logic       wr_done,
  input logic [3:0] tenths,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [2:0] dow,
  input logic       running
);
  logic load_acc, done_acc;
  assign load_acc = wr_en & wr_stb;
  assign done_acc = wr_en & wr_done;

  // R2
  tenths_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenths <= 4'd9);

  // R2
  tenths_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !load_acc && !done_acc && tenths != 4'd9)
    |=> tenths == $past(tenths) + 4'd1);

  // R3
  sec_min_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= 8'h59 && sec[3:0] <= 4'd9 && min <= 8'h59 && min[3:0] <= 4'd9);

  // R6
  month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    month >= 8'h01 && month <= 8'h12);

  // R8
  dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dow <= 3'd6);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_en && running) && !load_acc)
    |=> $stable({sec, min, hour, date, month, year, dow}));

  // R10
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> tenths == 4'd0);

  // R11
  done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> running && tenths == 4'd0);

  // R11
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

bind bcd_calendar_top cal_chk u_cal_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .wr_stb  (wr_stb),
  .wr_done (wr_done),
  .tenths  (tenths),
  .sec     (sec),
  .min     (min),
  .hour    (hour),
  .date    (date),
  .month   (month),
  .year    (year),
  .dow     (dow),
  .running (running)
);

// File: tb/test_bcd_calendar_top.sv
`timescale 1ns/1ps
module test_bcd_calendar_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, wr_en, wr_stb, wr_done;
  logic [7:0] wr_sec, wr_min, wr_hour, wr_date, wr_month, wr_year;
  logic [2:0] wr_dow;
  logic [3:0] tenths;
  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] dow;
  logic       running;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_top i_bcd_calendar_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_stb(wr_stb), .wr_done(wr_done), .wr_sec(wr_sec), .wr_min(wr_min),
    .wr_hour(wr_hour), .wr_date(wr_date), .wr_month(wr_month),
    .wr_year(wr_year), .wr_dow(wr_dow), .tenths(tenths), .sec(sec),
    .min(min), .hour(hour), .date(date), .month(month), .year(year),
    .dow(dow), .running(running)
  );

  typedef struct packed {
    logic [7:0]  s_sec, s_min, s_hour, s_date, s_mon, s_yr;
    logic [2:0]  s_dow;
    logic [7:0]  nt;
    logic [54:0] exp;   // {tenths, sec, min, hour, date, month, year, dow}
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    // R3 seconds wrap into minutes
    '{8'h59,8'h00,8'h90,8'h01,8'h01,8'h00,3'd0,8'd10,{4'd0,8'h00,8'h01,8'h90,8'h01,8'h01,8'h00,3'd0}},
    // R3 low digit carry
    '{8'h09,8'h00,8'h90,8'h01,8'h01,8'h00,3'd0,8'd10,{4'd0,8'h10,8'h00,8'h90,8'h01,8'h01,8'h00,3'd0}},
    // R4 hour digit carry 09 -> 10
    '{8'h59,8'h59,8'h89,8'h15,8'h06,8'h07,3'd3,8'd10,{4'd0,8'h00,8'h00,8'h90,8'h15,8'h06,8'h07,3'd3}},
    // R4 R6 R8 full rollover, year 99 -> 00, weekday 6 -> 0
    '{8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,3'd6,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,3'd0}},
    // R5 11 morning -> 12 afternoon
    '{8'h59,8'h59,8'h11,8'h10,8'h03,8'h05,3'd2,8'd10,{4'd0,8'h00,8'h00,8'h32,8'h10,8'h03,8'h05,3'd2}},
    // R5 11 afternoon -> 12 morning, day advances
    '{8'h59,8'h59,8'h31,8'h05,8'h03,8'h05,3'd2,8'd10,{4'd0,8'h00,8'h00,8'h12,8'h06,8'h03,8'h05,3'd3}},
    // R5 12 afternoon -> 1 afternoon
    '{8'h59,8'h59,8'h32,8'h05,8'h03,8'h05,3'd2,8'd10,{4'd0,8'h00,8'h00,8'h21,8'h05,8'h03,8'h05,3'd2}},
    // R5 12 morning -> 1 morning
    '{8'h59,8'h59,8'h12,8'h05,8'h03,8'h05,3'd2,8'd10,{4'd0,8'h00,8'h00,8'h01,8'h05,8'h03,8'h05,3'd2}},
    // R7 year 24: Feb 28 -> 29
    '{8'h59,8'h59,8'hA3,8'h28,8'h02,8'h24,3'd1,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h29,8'h02,8'h24,3'd2}},
    // R7 year 23: Feb 28 -> Mar 1
    '{8'h59,8'h59,8'hA3,8'h28,8'h02,8'h23,3'd1,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h03,8'h23,3'd2}},
    // R7 year 00: Feb 29 -> Mar 1
    '{8'h59,8'h59,8'hA3,8'h29,8'h02,8'h00,3'd4,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h03,8'h00,3'd5}},
    // R7 year 00: Feb 28 -> 29
    '{8'h59,8'h59,8'hA3,8'h28,8'h02,8'h00,3'd4,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h29,8'h02,8'h00,3'd5}},
    // R7 year 10: Feb 28 -> Mar 1
    '{8'h59,8'h59,8'hA3,8'h28,8'h02,8'h10,3'd4,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h03,8'h10,3'd5}},
    // R6 April 30 -> May 1
    '{8'h59,8'h59,8'hA3,8'h30,8'h04,8'h21,3'd0,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h05,8'h21,3'd1}},
    // R6 January 31 -> February 1
    '{8'h59,8'h59,8'hA3,8'h31,8'h01,8'h21,3'd0,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h02,8'h21,3'd1}},
    // R6 November 30 -> December 1
    '{8'h59,8'h59,8'hA3,8'h30,8'h11,8'h21,3'd0,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h12,8'h21,3'd1}},
    // R6 September 30 -> October 1
    '{8'h59,8'h59,8'hA3,8'h30,8'h09,8'h21,3'd0,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h10,8'h21,3'd1}},
    // R2 partial second: seven tenths, nothing else moves
    '{8'h00,8'h00,8'h90,8'h01,8'h01,8'h00,3'd0,8'd7, {4'd7,8'h00,8'h00,8'h90,8'h01,8'h01,8'h00,3'd0}},
    // R6 December 31 -> January 1, year 45 -> 46
    '{8'h59,8'h59,8'hA3,8'h31,8'h12,8'h45,3'd5,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h01,8'h01,8'h46,3'd6}},
    // R6 May 30 -> 31
    '{8'h59,8'h59,8'hA3,8'h30,8'h05,8'h21,3'd0,8'd10,{4'd0,8'h00,8'h00,8'h80,8'h31,8'h05,8'h21,3'd1}}
  };

  function automatic string vtag(input int i);
    if (i < 2)        return "R3";
    else if (i < 4)   return "R4";
    else if (i < 8)   return "R5";
    else if (i < 13)  return "R7";
    else if (i == 17) return "R2";
    else              return "R6";
  endfunction

  function automatic logic [63:0] snap();
    return {9'd0, tenths, sec, min, hour, date, month, year, dow};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, mi, h, d, mo, y, input logic [2:0] w,
                      input logic done);
    wr_sec = s; wr_min = mi; wr_hour = h; wr_date = d;
    wr_month = mo; wr_year = y; wr_dow = w;
    wr_stb = 1'b1; wr_done = done;
    @(negedge clk);
    wr_stb = 1'b0; wr_done = 1'b0;
  endtask

  localparam logic [63:0] RST_VAL = {9'd0, 4'd0, 8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 3'd0};

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_stb = 1'b0; wr_done = 1'b0;
    wr_sec = '0; wr_min = '0; wr_hour = '0; wr_date = '0;
    wr_month = '0; wr_year = '0; wr_dow = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset fields", snap(), RST_VAL);
    chk("R1 reset running", 64'(running), 64'd0);
    // R1 ticks ignored before a completion strobe
    ticks(15);
    chk("R1 idle ticks", snap(), RST_VAL);

    // R9 load with write-enable low is ignored; R11 strobe ignored too
    load(8'h33, 8'h22, 8'h91, 8'h07, 8'h07, 8'h07, 3'd3, 1'b1);
    chk("R9 gated load", snap(), RST_VAL);
    chk("R11 gated start", 64'(running), 64'd0);

    wr_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      load(VEC[i].s_sec, VEC[i].s_min, VEC[i].s_hour, VEC[i].s_date,
           VEC[i].s_mon, VEC[i].s_yr, VEC[i].s_dow, 1'b1);
      ticks(int'(VEC[i].nt));
      chk($sformatf("%s vector %0d", vtag(i), i), snap(), 64'(VEC[i].exp));
    end
    chk("R11 running set", 64'(running), 64'd1);

    // R2 tenths counting
    load(8'h00, 8'h00, 8'h90, 8'h01, 8'h01, 8'h00, 3'd0, 1'b1);
    ticks(3);
    chk("R2 three tenths", 64'(tenths), 64'd3);
    // R10 load without strobe clears tenths
    load(8'h30, 8'h00, 8'h90, 8'h01, 8'h01, 8'h00, 3'd0, 1'b0);
    chk("R10 tenths cleared", {56'(tenths), sec}, {56'd0, 8'h30});
    ticks(9);
    chk("R2 nine tenths", {56'(tenths), sec}, {56'd9, 8'h30});
    // R9 load beats a coincident tick at tenths 9
    tick_en = 1'b1;
    load(8'h45, 8'h00, 8'h90, 8'h01, 8'h01, 8'h00, 3'd0, 1'b0);
    tick_en = 1'b0;
    chk("R9 load priority", {56'(tenths), sec}, {56'd0, 8'h45});

    // R11 strobe mid-second realigns the divider
    ticks(6);
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    chk("R11 realign clear", 64'(tenths), 64'd0);
    ticks(9);
    chk("R11 no early step", {56'(tenths), sec}, {56'd9, 8'h45});
    ticks(1);
    chk("R11 full second", {56'(tenths), sec}, {56'd0, 8'h46});

    // R11 strobe with write-enable low leaves the phase alone
    ticks(4);
    wr_en = 1'b0;
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    chk("R11 gated strobe", 64'(tenths), 64'd4);
    // R9 gated load while running
    load(8'h11, 8'h11, 8'h91, 8'h11, 8'h11, 8'h11, 3'd1, 1'b0);
    chk("R9 gated load running", {56'(tenths), sec}, {56'd4, 8'h46});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule